// File: doc/BRIEF.md
# Power-State Interrupt Aggregator

This block turns three power-state event lines into one interrupt request, in two levels. Each event line has a sticky status bit. The bit is set by a rising edge on the event. Software clears it by writing a 1. A per-bit mask decides which latched bits feed the primary power-state bit. That primary bit sits next to other level-type primary sources. Each primary source has its own mask, and the unmasked primary bits are ORed onto a single interrupt line.

Software reaches the registers through a one-cycle synchronous port with a 16-bit address. A write takes effect at the clock edge where the write strobe is high. Read data is combinational from the address.

A status bit records its event even while its mask is set. Software can therefore poll events without taking an interrupt for them.

Top module: `pwr_irq_aggr`

## Requirements
- R1: After reset the event-status register (0x4012) reads 0, the event-mask register (0x401A) reads 0x0007, the primary-mask register (0x4018) reads 0x0003, and `irq` is 0.
- R2: A status bit at 0x4012 is set at the first clock edge where its event input is 1 after having been 0 at the previous edge. Event bit 2 is power-on, bit 1 is entry to sleep/off, and bit 0 is entry to on/wake. An input held at 1 does not set the bit again after it has been cleared.
- R3: A write to 0x4012 clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R4: When a rising edge and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bits latch and read back whatever the value of their mask bits.
- R6: Bit 0 of the primary-status register (0x4010, read-only) is 1 exactly when some status bit is 1 while its event-mask bit is 0. Primary-status bit 1 reads the `pri_aux` input level.
- R7: `irq` is 1 exactly when some primary-status bit is 1 while its bit in the primary mask (0x4018) is 0, with a mask bit of 1 meaning masked.
- R8: Reads of any other address return 0. Unused upper bits of every register read as 0 and ignore writes. Writes to 0x4010 have no effect.
- R9: The event-mask and primary-mask registers hold the value written to their low 3 and 2 bits respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt | input | 3 | Power-state event lines, synchronous to clk |
| pri_aux | input | 1 | Additional level primary source (primary bit 1) |
| addr | input | 16 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Aggregated interrupt request |

## Verification
An event or a register write is committed at the first rising edge where it is presented. Both the status readback and `irq` are therefore due by the next falling edge, because read data and `irq` are combinational from the registers. The bench drives every stimulus on a falling edge and waits one full cycle. It then changes `addr` and samples a moment later, so each result is compared exactly one register stage after its cause. The sweeps cover every combination of event pattern and event mask, every clear pattern, and every combination of primary mask, auxiliary level and power-state bit.

// File: rtl/pwr_irq_aggr.sv
module pwr_irq_aggr #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SEC_W  = 3,
  parameter int PRI_W  = 2,
  parameter logic [ADDR_W-1:0] A_PRI_STAT = 16'h4010,
  parameter logic [ADDR_W-1:0] A_SEC_STAT = 16'h4012,
  parameter logic [ADDR_W-1:0] A_PRI_MASK = 16'h4018,
  parameter logic [ADDR_W-1:0] A_SEC_MASK = 16'h401A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEC_W-1:0]  evt,
  input  logic [PRI_W-2:0]  pri_aux,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [SEC_W-1:0] evt_q, sec_stat, sec_mask;
  logic [PRI_W-1:0] pri_mask, pri_stat;

  wire sel_pstat = addr == A_PRI_STAT;
  wire sel_sstat = addr == A_SEC_STAT;
  wire sel_pmask = addr == A_PRI_MASK;
  wire sel_smask = addr == A_SEC_MASK;

  wire [SEC_W-1:0] rise = evt & ~evt_q;
  wire [SEC_W-1:0] clr  = (wr_en && sel_sstat) ? wdata[SEC_W-1:0] : '0;

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:SEC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q    <= '0;
      sec_stat <= '0;
      sec_mask <= '1;
      pri_mask <= '1;
    end else begin
      evt_q    <= evt;
      sec_stat <= (sec_stat & ~clr) | rise;
      if (wr_en && sel_smask) sec_mask <= wdata[SEC_W-1:0];
      if (wr_en && sel_pmask) pri_mask <= wdata[PRI_W-1:0];
    end
  end

  assign pri_stat = {pri_aux, |(sec_stat & ~sec_mask)};
  assign irq      = |(pri_stat & ~pri_mask);

  always_comb begin
    rdata = '0;
    if (sel_pstat) rdata = DATA_W'(pri_stat);
    if (sel_sstat) rdata = DATA_W'(sec_stat);
    if (sel_pmask) rdata = DATA_W'(pri_mask);
    if (sel_smask) rdata = DATA_W'(sec_mask);
  end
endmodule

module pwr_irq_aggr_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SEC_W  = 3,
  parameter int PRI_W  = 2,
  parameter logic [ADDR_W-1:0] A_SEC_STAT = 16'h4012
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEC_W-1:0]  evt,
  input logic [PRI_W-2:0]  pri_aux,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic [SEC_W-1:0]  sec_stat,
  input logic [SEC_W-1:0]  sec_mask,
  input logic [PRI_W-1:0]  pri_mask
);
  logic [SEC_W-1:0] evt_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) evt_d <= '0;
    else        evt_d <= evt;

  wire [SEC_W-1:0] edge_seen = evt & ~evt_d;
  wire stat_wr = wr_en && (addr == A_SEC_STAT);

  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_seen) |=> ((sec_stat & $past(edge_seen)) == $past(edge_seen)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && edge_seen == '0) |=>
      (sec_stat == ($past(sec_stat) & ~$past(wdata[SEC_W-1:0]))));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && (|(edge_seen & wdata[SEC_W-1:0]))) |=>
      ((sec_stat & $past(edge_seen)) == $past(edge_seen)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && edge_seen == '0) |=> $stable(sec_stat));

  p_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|pri_aux) || (|(sec_stat & ~sec_mask))));

  p_all_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&pri_mask) |-> !irq);
endmodule

bind pwr_irq_aggr pwr_irq_aggr_chk u_chk (.*);

// File: tb/pwr_irq_aggr_tb.sv
module pwr_irq_aggr_tb;
  localparam int CLK_NS = 10;
  localparam logic [15:0] PSTAT = 16'h4010, SSTAT = 16'h4012,
                          PMASK = 16'h4018, SMASK = 16'h401A;

  logic clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [2:0] evt = '0;
  logic [0:0] pri_aux = '0;
  logic [15:0] addr = '0, wdata = '0, rdata;
  int n_run = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  pwr_irq_aggr u_dut (.clk, .rst_n, .evt, .pri_aux, .addr, .wr_en,
                      .wdata, .rdata, .irq);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(string req, logic [15:0] a, logic [15:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic pulse(logic [2:0] p);
    @(negedge clk); evt = p;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd("R1 sec stat", SSTAT, 16'h0000);
    rd("R1 sec mask", SMASK, 16'h0007);
    rd("R1 pri mask", PMASK, 16'h0003);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    // R1/R5 masked default: event latched, no irq
    pulse(3'b100);
    rd("R5 latched while masked", SSTAT, 16'h0004);
    chk("R1 irq stays low", {15'd0, irq}, 16'h0000);

    // R2 R5 R6 R7 R9 sweep over masks and event patterns
    wr(PMASK, 16'h0002);
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 8; p++) begin
        logic ps;
        wr(SSTAT, 16'h0007);
        wr(SMASK, 16'(m));
        pulse(3'(p));
        ps = |(3'(p) & ~3'(m));
        rd("R9 sec mask readback", SMASK, 16'(m));
        rd("R2 R5 stat", SSTAT, 16'(p));
        rd("R6 pri stat", PSTAT, {15'd0, ps});
        chk("R7 irq", {15'd0, irq}, {15'd0, ps});
      end
    end

    // R3 clear patterns
    wr(SMASK, 16'h0000);
    for (int q = 0; q < 8; q++) begin
      wr(SSTAT, 16'h0007);
      pulse(3'b111);
      wr(SSTAT, 16'(q));
      @(negedge clk);
      rd("R3 partial clear", SSTAT, 16'(3'b111 & ~3'(q)));
    end
    // R8 upper data bits ignored on clear
    wr(SSTAT, 16'h0007);
    pulse(3'b101);
    wr(SSTAT, 16'hFFF8);
    rd("R8 upper bits no clear", SSTAT, 16'h0005);

    // R2 held level does not re-set
    wr(SSTAT, 16'h0007);
    @(negedge clk); evt = 3'b001;
    @(negedge clk);
    wr(SSTAT, 16'h0001);
    @(negedge clk);
    rd("R2 held level", SSTAT, 16'h0000);
    evt = '0;
    @(negedge clk);

    // R4 set wins over clear
    @(negedge clk); evt = 3'b111; addr = SSTAT; wdata = 16'h0007; wr_en = 1;
    @(negedge clk); wr_en = 0; evt = '0;
    rd("R4 set wins", SSTAT, 16'h0007);

    // R6 R7 primary level sweep
    wr(SMASK, 16'h0006);
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 2; a++)
        for (int k = 0; k < 4; k++) begin
          logic [1:0] pv;
          wr(SSTAT, 16'h0007);
          if (s == 1) pulse(3'b001);
          pri_aux = 1'(a);
          wr(PMASK, 16'(k));
          pv = {1'(a), 1'(s)};
          rd("R6 pri stat", PSTAT, {14'd0, pv});
          rd("R9 pri mask readback", PMASK, 16'(k));
          chk("R7 irq primary", {15'd0, irq}, {15'd0, |(pv & ~2'(k))});
        end
    pri_aux = '0;

    // R8 unmapped and read-only
    rd("R8 addr 0", 16'h0000, 16'h0000);
    rd("R8 addr 4011", 16'h4011, 16'h0000);
    rd("R8 addr C012", 16'hC012, 16'h0000);
    wr(SSTAT, 16'h0007);
    wr(SMASK, 16'h0000);
    pulse(3'b010);
    wr(PSTAT, 16'h0000);
    rd("R8 pri stat write ignored", PSTAT, 16'h0001);
    wr(SMASK, 16'hFFFF);
    rd("R8 sec mask upper", SMASK, 16'h0007);
    wr(PMASK, 16'hFFFC);
    rd("R8 pri mask upper", PMASK, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule